// File: doc/BRIEF.md
# Lookup-Table Branch Condition Combiner

This block resolves whether a shader-core branch is taken. The branch instruction carries a 16-bit function field that is a complete truth table over up to four one-bit conditions. The block picks the bit that the current conditions address and reports it as the branch decision. No compare or logic operation is fixed in hardware. Any boolean function of the conditions, including its inverse, is expressed by choosing the field value.

Conditions arrive on four condition-register lanes named x, y, z and w. The vector unit places its condition on the x lane and the scalar unit places its condition on the w lane. A mode input selects one of three table forms: a four-condition 16-entry table, a three-condition 8-entry table, or a one-condition 2-entry code. Inputs are captured when `inValid` is high, and the decision appears one clock later together with `outValid`.

Top module: `branch_lut_combiner`

## Requirements
- R1: With mode 2 or 3 (four conditions), A = condLanes[0] (x), B = condLanes[1] (y), C = condLanes[2] (z) and D = condLanes[3] (w). The table index is {A,C,D,B} with A as the most significant bit, and taken = funcField[index].
- R2: In four-condition mode, field 16'h8000 gives taken only when all four lanes are 1. Its complement, 16'h7FFF, gives the opposite result for every lane combination.
- R3: In four-condition mode, field 16'hF0F0 makes taken equal to lane z (condition C) for every lane combination.
- R4: With mode 1 (three conditions), the index is {0, x, z, y} with x as the most significant of the three. The w lane and funcField[15:8] have no effect on taken.
- R5: With mode 0 (one condition), the code is funcField[1:0]. Code 1 means taken when the condition is 0, code 2 means taken when it is 1, and code 3 means always taken. funcField[15:2] has no effect.
- R6: In one-condition mode, srcScalar = 1 takes the condition from the w lane and srcScalar = 0 takes it from the x lane.
- R7: In one-condition mode, code 0 resolves as not taken and raises reservedCode for the single cycle in which that result is presented.
- R8: The result for inputs sampled with inValid high appears on taken one clock later, with outValid high in that cycle. outValid is low in the cycle after inValid was low.
- R9: While inValid is low, taken keeps its previous value and reservedCode stays low.
- R10: A synchronous active-high rst clears outValid, taken and reservedCode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Inputs are sampled this cycle |
| mode | input | 2 | 0 one condition, 1 three conditions, 2 or 3 four conditions |
| srcScalar | input | 1 | One-condition source: 1 selects the w lane, 0 selects the x lane |
| condLanes | input | 4 | Condition lanes: bit 0 x, bit 1 y, bit 2 z, bit 3 w |
| funcField | input | 16 | Truth table or one-condition code from the instruction |
| outValid | output | 1 | Decision valid this cycle |
| taken | output | 1 | Branch-taken decision |
| reservedCode | output | 1 | One-condition code 0 was used |

## Verification
The bench sweeps all 16 lane combinations under several tables. A lane permutation that is wrong, even by one swapped pair, shows up as a mismatch on an asymmetric table such as 16'hA5C3, even when 16'h8000 and its complement look correct. In three-condition mode, the high byte and the w lane are loaded with values unrelated to the low byte. A design that lets index bit 3 through would read the wrong half. One-condition mode is run with junk in the upper field bits and from both source lanes, to expose a wrong lane choice or a wide index. Code 0 checks that reservedCode pulses once and that taken is cleared, and idle cycles check that the decision is held rather than recomputed.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  localparam int COND_LANES = 4;
  localparam int FIELD_W = 1 << COND_LANES;
  localparam int CODE_W = 2;

  typedef enum logic [1:0] {
    MODE_ONE      = 2'd0,
    MODE_THREE    = 2'd1,
    MODE_FOUR     = 2'd2,
    MODE_FOUR_ALT = 2'd3
  } condMode_e;

  typedef struct packed {
    logic load;
    logic useOne;
    logic useThree;
    logic srcScalar;
  } bccStrobe_t;
endpackage

// File: rtl/bcc_ctrl.sv
module bcc_ctrl
  import bcc_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] mode,
  input  logic       srcScalar,
  output bccStrobe_t strobe
);
  condMode_e modeSel;

  always_comb begin
    modeSel = condMode_e'(mode);
    strobe.load = inValid;
    strobe.useOne = (modeSel == MODE_ONE);
    strobe.useThree = (modeSel == MODE_THREE);
    strobe.srcScalar = srcScalar;
  end
endmodule

// File: rtl/bcc_datapath.sv
module bcc_datapath
  import bcc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  bccStrobe_t            strobe,
  input  logic [COND_LANES-1:0] condLanes,
  input  logic [FIELD_W-1:0]    funcField,
  output logic                  outValid,
  output logic                  taken,
  output logic                  reservedCode
);
  localparam int IDX_W = COND_LANES;
  localparam int LANE_X = 0;
  localparam int LANE_Y = 1;
  localparam int LANE_Z = 2;
  localparam int LANE_W = COND_LANES - 1;

  logic [IDX_W-1:0]  idxFour;
  logic [IDX_W-1:0]  idxThree;
  logic [IDX_W-1:0]  idxWide;
  logic [CODE_W-1:0] oneCode;
  logic              oneCond;
  logic              oneTaken;
  logic              wideTaken;
  logic              nextTaken;
  logic              isReserved;

  always_comb begin
    idxFour  = {condLanes[LANE_X], condLanes[LANE_Z], condLanes[LANE_W], condLanes[LANE_Y]};
    idxThree = {1'b0, condLanes[LANE_X], condLanes[LANE_Z], condLanes[LANE_Y]};
    idxWide  = strobe.useThree ? idxThree : idxFour;
    wideTaken = funcField[idxWide];
    oneCode = funcField[CODE_W-1:0];
    oneCond = strobe.srcScalar ? condLanes[LANE_W] : condLanes[LANE_X];
    oneTaken = oneCode[oneCond];
    isReserved = strobe.useOne && (oneCode == '0);
    nextTaken = strobe.useOne ? oneTaken : wideTaken;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      taken <= 1'b0;
      reservedCode <= 1'b0;
    end else begin
      outValid <= strobe.load;
      reservedCode <= strobe.load && isReserved;
      if (strobe.load) taken <= nextTaken;
    end
  end
endmodule

// File: rtl/branch_lut_combiner.sv
module branch_lut_combiner
  import bcc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [1:0]  mode,
  input  logic        srcScalar,
  input  logic [3:0]  condLanes,
  input  logic [15:0] funcField,
  output logic        outValid,
  output logic        taken,
  output logic        reservedCode
);
  bccStrobe_t strobe;

  bcc_ctrl u_ctrl (
    .inValid(inValid),
    .mode(mode),
    .srcScalar(srcScalar),
    .strobe(strobe)
  );

  bcc_datapath u_dp (
    .clk(clk),
    .rst(rst),
    .strobe(strobe),
    .condLanes(condLanes),
    .funcField(funcField),
    .outValid(outValid),
    .taken(taken),
    .reservedCode(reservedCode)
  );
endmodule

// File: rtl/branch_lut_combiner_chk.sv
module branch_lut_combiner_chk (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic [1:0]  mode,
  input logic        srcScalar,
  input logic [3:0]  condLanes,
  input logic [15:0] funcField,
  input logic        outValid,
  input logic        taken,
  input logic        reservedCode
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R8
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(taken) && !reservedCode)); // R9
  AST_RESERVED_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    reservedCode |-> (outValid && !taken)); // R7
  AST_RESERVED_RAISED: assert property (@(posedge clk) disable iff (rst)
    (inValid && mode == 2'd0 && funcField[1:0] == 2'd0) |=> reservedCode); // R7
  AST_ONE_ALWAYS: assert property (@(posedge clk) disable iff (rst)
    (inValid && mode == 2'd0 && funcField[1:0] == 2'd3) |=> taken); // R5
  AST_AND_ALL: assert property (@(posedge clk) disable iff (rst)
    (inValid && mode[1] && funcField == 16'h8000) |=> (taken == $past(&condLanes))); // R2
  AST_SELECT_Z: assert property (@(posedge clk) disable iff (rst)
    (inValid && mode[1] && funcField == 16'hF0F0) |=> (taken == $past(condLanes[2]))); // R3
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!outValid && !taken && !reservedCode)); // R10
endmodule

bind branch_lut_combiner branch_lut_combiner_chk u_chk (.*);

// File: tb/branch_lut_combiner_tb.sv
module branch_lut_combiner_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 50000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        srcScalar = 1'b0;
  logic [3:0]  condLanes = 4'd0;
  logic [15:0] funcField = 16'd0;
  logic        outValid;
  logic        taken;
  logic        reservedCode;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_lut_combiner u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .mode(mode), .srcScalar(srcScalar),
    .condLanes(condLanes), .funcField(funcField), .outValid(outValid),
    .taken(taken), .reservedCode(reservedCode)
  );

  function automatic logic refTaken(input logic [1:0] m, input logic s,
                                    input logic [15:0] f, input logic [3:0] c);
    int idx;
    int bitSel;
    if (m == 2'd0) begin
      bitSel = s ? int'(c[3]) : int'(c[0]);
      return f[bitSel];
    end else if (m == 2'd1) begin
      idx = 4 * int'(c[0]) + 2 * int'(c[2]) + int'(c[1]);
      return f[idx];
    end
    idx = 8 * int'(c[0]) + 4 * int'(c[2]) + 2 * int'(c[3]) + int'(c[1]);
    return f[idx];
  endfunction

  task automatic check(input string req, input logic v, input logic t, input logic r,
                       input logic ev, input logic et, input logic er);
    checks++;
    if (v !== ev || t !== et || r !== er) begin
      failures++;
      $display("FAIL %s: got valid=%0b taken=%0b reserved=%0b expected valid=%0b taken=%0b reserved=%0b",
               req, v, t, r, ev, et, er);
    end
  endtask

  task automatic runOne(input string req, input logic [1:0] m, input logic s,
                        input logic [15:0] f, input logic [3:0] c);
    logic expTaken;
    logic expRes;
    @(negedge clk);
    inValid = 1'b1; mode = m; srcScalar = s; funcField = f; condLanes = c;
    expTaken = refTaken(m, s, f, c);
    expRes = (m == 2'd0) && (f[1:0] == 2'd0);
    if (expRes) expTaken = 1'b0;
    @(negedge clk);
    check(req, outValid, taken, reservedCode, 1'b1, expTaken, expRes);
    inValid = 1'b0;
  endtask

  task automatic sweepFour(input string req, input logic [15:0] f, input logic [1:0] m);
    for (int c = 0; c < 16; c++) runOne(req, m, 1'b0, f, 4'(c));
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < WATCHDOG_CYCLES) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    logic heldTaken;
    repeat (3) @(negedge clk);
    check("R10 reset", outValid, taken, reservedCode, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;

    // R1 asymmetric tables catch permutation errors; R2 and-all and its complement; R3 z select
    sweepFour("R1", 16'hA5C3, 2'd2);
    sweepFour("R1", 16'h1234, 2'd3);
    sweepFour("R2", 16'h8000, 2'd2);
    sweepFour("R2", 16'h7FFF, 2'd2);
    sweepFour("R3", 16'hF0F0, 2'd2);
    for (int c = 0; c < 16; c++) begin
      runOne("R1", 2'd2, 1'b0, 16'(16'h0001 << c), 4'(c));
    end

    // R4 three conditions: high byte and w lane are junk
    for (int c = 0; c < 16; c++) begin
      runOne("R4", 2'd1, 1'b0, 16'h5B96, 4'(c));
      runOne("R4", 2'd1, 1'b0, 16'hFF00 | 16'h0069, 4'(c));
      runOne("R4", 2'd1, 1'b0, 16'h00E8, 4'(c));
    end

    // R5 R6 R7 one-condition codes from both source lanes with junk upper bits
    for (int code = 0; code < 4; code++) begin
      for (int s = 0; s < 2; s++) begin
        for (int c = 0; c < 16; c++) begin
          runOne(code == 0 ? "R7" : (s == 1 ? "R6" : "R5"), 2'd0, 1'(s),
                 16'hBEE0 | 16'(code), 4'(c));
        end
      end
    end

    // R7 reserved flag lasts a single cycle
    runOne("R7", 2'd0, 1'b0, 16'h0000, 4'h1);
    @(negedge clk);
    check("R7 one-cycle", outValid, taken, reservedCode, 1'b0, 1'b0, 1'b0);

    // R9 idle cycles hold the decision while inputs change
    runOne("R9", 2'd0, 1'b0, 16'h0003, 4'h0);
    heldTaken = 1'b1;
    @(negedge clk);
    mode = 2'd2; funcField = 16'h0000; condLanes = 4'hF;
    @(negedge clk);
    check("R9 hold", outValid, taken, reservedCode, 1'b0, heldTaken, 1'b0);
    funcField = 16'h0000; mode = 2'd0;
    @(negedge clk);
    check("R9 hold", outValid, taken, reservedCode, 1'b0, heldTaken, 1'b0);

    // R8 back-to-back valid inputs each produce a result one clock later
    @(negedge clk);
    inValid = 1'b1; mode = 2'd2; funcField = 16'h8000; condLanes = 4'hF;
    @(negedge clk);
    check("R8 first", outValid, taken, reservedCode, 1'b1, 1'b1, 1'b0);
    condLanes = 4'hE;
    @(negedge clk);
    check("R8 second", outValid, taken, reservedCode, 1'b1, 1'b0, 1'b0);
    inValid = 1'b0;
    @(negedge clk);
    check("R8 drop", outValid, taken, reservedCode, 1'b0, 1'b0, 1'b0);

    // R10 reset after a taken result
    runOne("R10 setup", 2'd0, 1'b0, 16'h0003, 4'h0);
    rst = 1'b1;
    @(negedge clk);
    check("R10 mid-run", outValid, taken, reservedCode, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule